// File: doc/BRIEF.md
# Two-Level Option Register Unlock Controller

This block protects a bank of option configuration registers behind two nested locks. The outer lock belongs to the main control register. Its key logic sits outside this block and arrives here as a level, `main_locked`, and as a one-cycle pulse, `main_lock_set`, that marks software setting it. The inner lock is the option lock, and this block owns it. Software clears the option lock by writing two fixed 32-bit keys, one after the other, to a key register. It may only do so while the outer lock is open. Any mistake freezes the option lock shut until reset, and the offending write gets a bus error response that the system turns into a hard fault.

The controller is a four-state machine:

- `ST_LOCKED` is the reset state.
- `ST_KEY1_OK` means the first key has been seen.
- `ST_UNLOCKED` means the option lock is clear.
- `ST_LOCKOUT` is sticky until reset.

The transitions are:

- *first-key* (LOCKED→KEY1_OK)
- *second-key* (KEY1_OK→UNLOCKED)
- *bad-key* (LOCKED or KEY1_OK→LOCKOUT, on a wrong value or on a key write while the main lock is set)
- *relock* (KEY1_OK or UNLOCKED→LOCKED, on a software lock write or on the main lock being set)

Option value writes pass to the option store only when the option lock is clear and the flash is neither busy nor suspended in program/erase. Any other option write is dropped with a bus error. All outputs are registered and change on the clock edge after the input that caused them.

Top module: `opt_unlock_ctrl`

## Requirements
- R1: After reset `opt_locked`=1, `key_lockout`=0, `key_stage`=0, `bus_err`=0, `opt_we`=0 and `opt_wdata`=0.
- R2: A key write while `main_locked`=1 and the option lock is set moves to lockout (`key_lockout`=1) and raises `bus_err` on the next cycle, whatever the key value.
- R3: With `main_locked`=0 in the locked state, writing 0x08192A3B sets `key_stage`=1 with no error, and `opt_locked` stays 1.
- R4: In the first-key state, writing 0x4C5D6E7F clears `opt_locked` and `key_stage` on the next cycle with no error. This is the only way `opt_locked` falls.
- R5: A wrong value at either step enters lockout with `bus_err`. In lockout `opt_locked` stays 1, later key writes (even correct ones) each give `bus_err`, and only reset leaves lockout.
- R6: `bus_err` is a one-cycle pulse in the cycle after the offending write, and is 0 otherwise.
- R7: `lock_wr_en`=1 sets `opt_locked`=1 and clears `key_stage` on the next cycle, from the first-key or unlocked state.
- R8: `main_lock_set`=1 sets `opt_locked`=1 and clears `key_stage` on the same edge that sets the main lock.
- R9: A key write while the option lock is clear is ignored: no state change and no `bus_err`.
- R10: An option write with `opt_locked`=0, `flash_busy`=0 and `pe_suspended`=0 gives `opt_we`=1 for one cycle next cycle, with `opt_wdata` equal to the written data. `opt_wdata` holds otherwise.
- R11: An option write while `opt_locked`=1, `flash_busy`=1 or `pe_suspended`=1 gives `opt_we`=0, leaves `opt_wdata` unchanged and raises `bus_err` next cycle.
- R12: A key write in the same cycle as `lock_wr_en` or `main_lock_set` is discarded: no error and no key progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_locked | input | 1 | Main control lock is set |
| main_lock_set | input | 1 | Pulse: software is setting the main lock |
| lock_wr_en | input | 1 | Pulse: software sets the option lock |
| key_wr_en | input | 1 | Write strobe to the option key register |
| key_wr_data | input | 32 | Key value written |
| opt_wr_en | input | 1 | Write strobe to the option value registers |
| opt_wr_data | input | 32 | Option value written |
| flash_busy | input | 1 | A flash operation is in progress |
| pe_suspended | input | 1 | Program/erase is suspended |
| opt_we | output | 1 | Accepted write strobe to the option store |
| opt_wdata | output | 32 | Accepted option value |
| bus_err | output | 1 | Error response for the previous cycle's write |
| opt_locked | output | 1 | Option lock status |
| key_lockout | output | 1 | Sticky lockout status |
| key_stage | output | 1 | First key accepted, second awaited |

## Verification
The bench goes after four kinds of corner case:

- **Key order and value.** It tries a key write before the main lock opens, a wrong first key, a wrong second key, and the second key sent first. A design that only matched values, or that skipped the main-lock check, would let the option lock open.
- **Lockout stickiness.** After a lockout the bench sends the correct two-key sequence again. A design that let the machine recover without reset would unlock there.
- **Relock collisions.** The bench relocks from the first-key state and aims a key write at the same cycle as a lock write. A design that kept `key_stage` would accept a lone second key later. A design with the wrong priority would report an error or advance.
- **Write gating.** Option writes go in under busy, under suspend and while locked. A design that missed any gate would pass `opt_we` or change `opt_wdata`.

// File: rtl/opt_unlock_pkg.sv
package opt_unlock_pkg;

    localparam int unsigned KEY_W_DEF = 32;
    localparam logic [31:0] KEY1_DEF  = 32'h0819_2A3B;
    localparam logic [31:0] KEY2_DEF  = 32'h4C5D_6E7F;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY1_OK  = 2'd1,
        ST_UNLOCKED = 2'd2,
        ST_LOCKOUT  = 2'd3
    } unlock_state_e;

endpackage

// File: rtl/opt_key_fsm.sv
module opt_key_fsm
    import opt_unlock_pkg::*;
#(
    parameter int unsigned       KEY_W = KEY_W_DEF,
    parameter logic [KEY_W-1:0]  KEY1  = KEY1_DEF[KEY_W-1:0],
    parameter logic [KEY_W-1:0]  KEY2  = KEY2_DEF[KEY_W-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_locked,
    input  logic             lock_req,
    input  logic             key_wr_en,
    input  logic [KEY_W-1:0] key_wr_data,
    output logic             key_bad,
    output logic             opt_locked,
    output logic             key_lockout,
    output logic             key_stage
);

    unlock_state_e state_q, state_d;

    logic hit1, hit2;
    assign hit1 = (key_wr_data == KEY1);
    assign hit2 = (key_wr_data == KEY2);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // next state and key error
    always_comb begin
        state_d = state_q;
        key_bad = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (lock_req) begin
                    state_d = ST_LOCKED;
                end else if (key_wr_en) begin
                    if (!main_locked && hit1) begin
                        state_d = ST_KEY1_OK;
                    end else begin
                        state_d = ST_LOCKOUT;
                        key_bad = 1'b1;
                    end
                end
            end
            ST_KEY1_OK: begin
                if (lock_req) begin
                    state_d = ST_LOCKED;
                end else if (key_wr_en) begin
                    if (!main_locked && hit2) begin
                        state_d = ST_UNLOCKED;
                    end else begin
                        state_d = ST_LOCKOUT;
                        key_bad = 1'b1;
                    end
                end
            end
            ST_UNLOCKED: begin
                if (lock_req) state_d = ST_LOCKED;
            end
            ST_LOCKOUT: begin
                state_d = ST_LOCKOUT;
                key_bad = key_wr_en && !lock_req;
            end
        endcase
    end

    // status outputs
    always_comb begin
        opt_locked  = (state_q != ST_UNLOCKED);
        key_lockout = (state_q == ST_LOCKOUT);
        key_stage   = (state_q == ST_KEY1_OK);
    end

endmodule

// File: rtl/opt_wr_gate.sv
module opt_wr_gate #(
    parameter int unsigned OPT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opt_locked,
    input  logic             flash_busy,
    input  logic             pe_suspended,
    input  logic             opt_wr_en,
    input  logic [OPT_W-1:0] opt_wr_data,
    input  logic             key_bad,
    output logic             opt_we,
    output logic [OPT_W-1:0] opt_wdata,
    output logic             bus_err
);

    logic allow;
    assign allow = !opt_locked && !flash_busy && !pe_suspended;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_we    <= 1'b0;
            opt_wdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            opt_we  <= opt_wr_en && allow;
            bus_err <= key_bad || (opt_wr_en && !allow);
            if (opt_wr_en && allow) opt_wdata <= opt_wr_data;
        end
    end

endmodule

// File: rtl/opt_unlock_ctrl.sv
module opt_unlock_ctrl
    import opt_unlock_pkg::*;
#(
    parameter int unsigned       KEY_W = KEY_W_DEF,
    parameter int unsigned       OPT_W = 32,
    parameter logic [KEY_W-1:0]  KEY1  = KEY1_DEF[KEY_W-1:0],
    parameter logic [KEY_W-1:0]  KEY2  = KEY2_DEF[KEY_W-1:0]
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_locked,
    input  logic             main_lock_set,
    input  logic             lock_wr_en,
    input  logic             key_wr_en,
    input  logic [KEY_W-1:0] key_wr_data,
    input  logic             opt_wr_en,
    input  logic [OPT_W-1:0] opt_wr_data,
    input  logic             flash_busy,
    input  logic             pe_suspended,
    output logic             opt_we,
    output logic [OPT_W-1:0] opt_wdata,
    output logic             bus_err,
    output logic             opt_locked,
    output logic             key_lockout,
    output logic             key_stage
);

    logic lock_req;
    logic key_bad;

    assign lock_req = main_lock_set || lock_wr_en;

    opt_key_fsm #(
        .KEY_W (KEY_W),
        .KEY1  (KEY1),
        .KEY2  (KEY2)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_locked (main_locked),
        .lock_req    (lock_req),
        .key_wr_en   (key_wr_en),
        .key_wr_data (key_wr_data),
        .key_bad     (key_bad),
        .opt_locked  (opt_locked),
        .key_lockout (key_lockout),
        .key_stage   (key_stage)
    );

    opt_wr_gate #(
        .OPT_W (OPT_W)
    ) gate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .opt_locked   (opt_locked),
        .flash_busy   (flash_busy),
        .pe_suspended (pe_suspended),
        .opt_wr_en    (opt_wr_en),
        .opt_wr_data  (opt_wr_data),
        .key_bad      (key_bad),
        .opt_we       (opt_we),
        .opt_wdata    (opt_wdata),
        .bus_err      (bus_err)
    );

endmodule

// File: rtl/opt_unlock_chk.sv
module opt_unlock_chk #(
    parameter int unsigned      KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY2  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             main_locked,
    input logic             main_lock_set,
    input logic             lock_wr_en,
    input logic             key_wr_en,
    input logic [KEY_W-1:0] key_wr_data,
    input logic             opt_wr_en,
    input logic             flash_busy,
    input logic             pe_suspended,
    input logic             opt_we,
    input logic             bus_err,
    input logic             opt_locked,
    input logic             key_lockout,
    input logic             key_stage
);

    p_bad_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr_en && main_locked && opt_locked && !main_lock_set && !lock_wr_en)
        |=> (key_lockout && bus_err));

    p_unlock_by_key2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(opt_locked) |->
        ($past(key_wr_en) && ($past(key_wr_data) == KEY2) && $past(key_stage)));

    p_lockout_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_lockout |=> (key_lockout && opt_locked));

    p_relock_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr_en |=> (opt_locked && !key_stage));

    p_relock_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
        main_lock_set |=> (opt_locked && !key_stage));

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opt_we |->
        $past(opt_wr_en && !opt_locked && !flash_busy && !pe_suspended));

    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_wr_en && (opt_locked || flash_busy || pe_suspended)) |=> (!opt_we && bus_err));

    p_status_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({key_lockout, key_stage, !opt_locked}));

endmodule

bind opt_unlock_ctrl opt_unlock_chk #(
    .KEY_W (KEY_W),
    .KEY2  (KEY2)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .main_locked   (main_locked),
    .main_lock_set (main_lock_set),
    .lock_wr_en    (lock_wr_en),
    .key_wr_en     (key_wr_en),
    .key_wr_data   (key_wr_data),
    .opt_wr_en     (opt_wr_en),
    .flash_busy    (flash_busy),
    .pe_suspended  (pe_suspended),
    .opt_we        (opt_we),
    .bus_err       (bus_err),
    .opt_locked    (opt_locked),
    .key_lockout   (key_lockout),
    .key_stage     (key_stage)
);

// File: tb/opt_unlock_ctrl_tb_top.sv
`timescale 1ns/1ps
module opt_unlock_ctrl_tb_top;

    localparam logic [31:0] K1 = 32'h0819_2A3B;
    localparam logic [31:0] K2 = 32'h4C5D_6E7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        main_locked = 1'b1, main_lock_set = 1'b0, lock_wr_en = 1'b0;
    logic        key_wr_en = 1'b0, opt_wr_en = 1'b0;
    logic [31:0] key_wr_data = '0, opt_wr_data = '0;
    logic        flash_busy = 1'b0, pe_suspended = 1'b0;
    logic        opt_we, bus_err, opt_locked, key_lockout, key_stage;
    logic [31:0] opt_wdata;

    always #4 clk = ~clk;

    opt_unlock_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .main_locked(main_locked),
        .main_lock_set(main_lock_set), .lock_wr_en(lock_wr_en),
        .key_wr_en(key_wr_en), .key_wr_data(key_wr_data),
        .opt_wr_en(opt_wr_en), .opt_wr_data(opt_wr_data),
        .flash_busy(flash_busy), .pe_suspended(pe_suspended),
        .opt_we(opt_we), .opt_wdata(opt_wdata), .bus_err(bus_err),
        .opt_locked(opt_locked), .key_lockout(key_lockout), .key_stage(key_stage)
    );

    // behavioural reference model
    bit          m_locked = 1, m_stage = 0, m_lockout = 0, m_err = 0, m_we = 0;
    bit   [31:0] m_wdata = 0;
    int          vectors = 0, miscompares = 0;
    string       cur_req = "R1";

    always @(posedge clk) begin
        bit nl, ns, nlo, ne, nw;
        nl = m_locked; ns = m_stage; nlo = m_lockout; ne = 0; nw = 0;
        if (!rst_n) begin
            m_locked <= 1; m_stage <= 0; m_lockout <= 0;
            m_err <= 0; m_we <= 0; m_wdata <= 0;
        end else begin
            if (opt_wr_en) begin
                if (!m_locked && !flash_busy && !pe_suspended) begin
                    nw = 1; m_wdata <= opt_wr_data;
                end else ne = 1;
            end
            if (main_lock_set || lock_wr_en) begin
                if (!m_lockout) begin nl = 1; ns = 0; end
            end else if (key_wr_en) begin
                if (m_lockout) ne = 1;
                else if (!m_locked) begin end
                else if (main_locked) begin nlo = 1; ns = 0; ne = 1; end
                else if (!m_stage) begin
                    if (key_wr_data == K1) ns = 1;
                    else begin nlo = 1; ne = 1; end
                end else begin
                    if (key_wr_data == K2) begin nl = 0; ns = 0; end
                    else begin nlo = 1; ns = 0; ne = 1; end
                end
            end
            m_locked <= nl; m_stage <= ns; m_lockout <= nlo; m_err <= ne; m_we <= nw;
        end
    end

    task automatic chk1(string what, logic act, bit exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk1("opt_locked", opt_locked, m_locked);
        chk1("key_stage", key_stage, m_stage);
        chk1("key_lockout", key_lockout, m_lockout);
        chk1("bus_err", bus_err, m_err);
        chk1("opt_we", opt_we, m_we);
        vectors++;
        if (opt_wdata !== m_wdata) begin
            miscompares++;
            $display("FAIL %s opt_wdata actual=%h expected=%h t=%0t", cur_req, opt_wdata, m_wdata, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        main_lock_set = 0; lock_wr_en = 0; key_wr_en = 0; opt_wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; main_locked = 1; flash_busy = 0; pe_suspended = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic key(logic [31:0] d);
        key_wr_en = 1; key_wr_data = d; tick(); tick();
    endtask

    task automatic optw(logic [31:0] d);
        opt_wr_en = 1; opt_wr_data = d; tick(); tick();
    endtask

    initial begin
        #1600000;
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1"; do_reset(); tick();
        cur_req = "R11"; optw(32'h1111_0001);
        cur_req = "R2"; key(K1);
        cur_req = "R5"; main_locked = 0; key(K1); key(K2);
        cur_req = "R6"; tick(); tick();

        cur_req = "R1"; do_reset(); main_locked = 0;
        cur_req = "R3"; key(K1);
        cur_req = "R4"; key(K2);
        cur_req = "R9"; key(K1); key(32'hDEAD_BEEF);
        cur_req = "R10"; optw(32'hA5A5_0102); optw(32'h0000_FFFF);
        cur_req = "R11"; flash_busy = 1; optw(32'h2222_0002); flash_busy = 0;
        pe_suspended = 1; optw(32'h3333_0003); pe_suspended = 0;
        cur_req = "R7"; lock_wr_en = 1; tick(); tick();
        cur_req = "R11"; optw(32'h4444_0004);
        cur_req = "R7"; key(K1); lock_wr_en = 1; tick();
        cur_req = "R5"; key(K2);

        cur_req = "R1"; do_reset(); main_locked = 0;
        cur_req = "R4"; key(K1); key(K2);
        cur_req = "R8"; main_lock_set = 1; main_locked = 1; tick(); tick();
        cur_req = "R2"; key(K1);

        cur_req = "R1"; do_reset(); main_locked = 0;
        cur_req = "R5"; key(32'h0819_2A3A); key(K1); key(K2);
        do_reset(); main_locked = 0;
        key(K1); key(K1); key(K1); key(K2);
        do_reset(); main_locked = 0;
        key(K2);

        cur_req = "R1"; do_reset(); main_locked = 0;
        cur_req = "R12"; key_wr_en = 1; key_wr_data = K1; lock_wr_en = 1; tick(); tick();
        key(K1);
        key_wr_en = 1; key_wr_data = 32'h0; main_lock_set = 1; tick(); tick();
        cur_req = "R4"; key(K1); key(K2);
        cur_req = "R12"; key_wr_en = 1; key_wr_data = 32'h1; lock_wr_en = 1; tick(); tick();
        cur_req = "R10"; key(K1); key(K2); optw(32'hCAFE_F00D);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule